// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache Controller

This block is a direct-mapped cache controller whose lines are split into sub-blocks of one 32-bit word each. All the sub-blocks of a line share one stored tag. Each sub-block has its own valid bit.

A load that misses asks the lower level for the single addressed sub-block only. A store writes the cache without any line fill and is always passed on to the lower level (write-through), so no dirty state exists. When an access brings in a different tag, the line's tag is replaced and every sibling sub-block is invalidated. When the tag matches but the addressed sub-block is invalid, the access is a partial miss: only that sub-block changes.

The CPU side takes one request at a time through a valid/ready handshake and answers with a one-cycle response pulse. The lower-level side carries one sub-block per request, as a read or as a write.

Top module: `subblk_cache`

## Requirements
- R1: After reset every sub-block is invalid and the controller is idle, with `cpu_req_ready`=1, `cpu_rsp_valid`=0 and `mem_req_valid`=0. The first load to any address therefore misses.
- R2: `cpu_rsp_hit`=1 marks a hit. A hit needs both a matching tag and the addressed sub-block's valid bit. A load hit returns the cached word and makes no lower-level request.
- R3: A load miss makes exactly one lower-level read, with `mem_req_write`=0. The read address is the word address with the byte bits [1:0] forced to 0, and the request stays stable until it is accepted. The load returns the word delivered on `mem_rsp_rdata`.
- R4: On a partial miss (tag matches, sub-block invalid) only the addressed sub-block is fetched. Sub-blocks of that line that were already valid stay valid and keep their data.
- R5: When a fill or a store brings a tag that differs from the line's stored tag, the tag is replaced and every other sub-block of that line becomes invalid.
- R6: A store miss makes no lower-level read. It writes the store data into the addressed sub-block and marks that sub-block valid. A later load of that word hits and returns the stored data.
- R7: Every store, hit or miss, makes exactly one lower-level write (`mem_req_write`=1) carrying the store data. A store hit replaces the cached word.
- R8: `cpu_req_ready` is high only while idle. It is low from the cycle after a request is accepted until the response cycle has passed. `cpu_rsp_valid` is a single-cycle pulse, and `cpu_req_ready` is high again in the following cycle.
- R9: With the default parameters the address fields are: bits [1:0] select the byte and are ignored; bits [3:2] select the sub-block; bits [6:4] form the index (log2 of 8 lines); bits [11:7] form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller accepts a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Access hit in the cache |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Lower-level request present |
| mem_req_ready | input | 1 | Lower level accepts request |
| mem_req_write | output | 1 | 1 = write-through, 0 = sub-block read |
| mem_req_addr | output | ADDR_W | Word-aligned address |
| mem_req_wdata | output | 32 | Write-through data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Returned sub-block |

## Verification
Two events can land on the same line in one update: a tag replacement that clears the sibling valid bits, and the setting of the new sub-block's valid bit. This happens both on a store to a new tag and on a load fill that brings a different tag. The bench provokes this by confining random traffic to two indexes and four tags, so that tags on the same line replace each other constantly, with stores and loads mixed. The outcome is judged through the hit flag and the data of later loads to the sibling sub-blocks and to the written sub-block, compared against a bench model of tags, valid bits and memory.

// File: rtl/subblk_cache.sv
module subblk_cache #(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8,
  parameter int SUBS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [31:0]       cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [31:0]       cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int SUB_W = $clog2(SUBS);
  localparam int TAG_W = ADDR_W - 2 - SUB_W - IDX_W;

  typedef enum logic [1:0] {IDLE, LOOKUP, FETCH, RESPOND} state_t;

  state_t            st_q;
  logic              wr_q, sent_q, hit_q;
  logic [ADDR_W-3:0] wa_q;
  logic [31:0]       wdata_q, rdata_q;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [SUBS-1:0]   vld_q  [LINES];
  logic [31:0]       data_q [LINES*SUBS];

  logic [IDX_W-1:0]       idx;
  logic [SUB_W-1:0]       sub;
  logic [TAG_W-1:0]       tag;
  logic [IDX_W+SUB_W-1:0] slot;
  logic tag_eq, hit, upd, unused_bits;
  logic [31:0] upd_data;

  assign unused_bits = ^cpu_req_addr[1:0];

  assign sub  = wa_q[0 +: SUB_W];
  assign idx  = wa_q[SUB_W +: IDX_W];
  assign tag  = wa_q[ADDR_W-3 -: TAG_W];
  assign slot = {idx, sub};

  assign tag_eq = (tag_q[idx] == tag);
  assign hit    = tag_eq && vld_q[idx][sub];

  assign upd      = (st_q == LOOKUP && wr_q) ||
                    (st_q == FETCH && !wr_q && sent_q && mem_rsp_valid);
  assign upd_data = wr_q ? wdata_q : mem_rsp_rdata;

  assign cpu_req_ready = (st_q == IDLE);
  assign cpu_rsp_valid = (st_q == RESPOND);
  assign cpu_rsp_hit   = hit_q;
  assign cpu_rsp_rdata = rdata_q;
  assign mem_req_valid = (st_q == FETCH) && !sent_q;
  assign mem_req_write = wr_q;
  assign mem_req_addr  = {wa_q, 2'b00};
  assign mem_req_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      wr_q    <= 1'b0;
      sent_q  <= 1'b0;
      hit_q   <= 1'b0;
      wa_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        IDLE: if (cpu_req_valid) begin
          wr_q    <= cpu_req_write;
          wa_q    <= cpu_req_addr[ADDR_W-1:2];
          wdata_q <= cpu_req_wdata;
          sent_q  <= 1'b0;
          st_q    <= LOOKUP;
        end
        LOOKUP: begin
          hit_q <= hit;
          if (wr_q) begin
            rdata_q <= wdata_q;
            st_q    <= FETCH;
          end else if (hit) begin
            rdata_q <= data_q[slot];
            st_q    <= RESPOND;
          end else begin
            st_q <= FETCH;
          end
        end
        FETCH: begin
          if (mem_req_valid && mem_req_ready) begin
            sent_q <= 1'b1;
            if (wr_q) st_q <= RESPOND;
          end
          if (!wr_q && sent_q && mem_rsp_valid) begin
            rdata_q <= mem_rsp_rdata;
            st_q    <= RESPOND;
          end
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (upd) begin
      if (!tag_eq) begin
        tag_q[idx] <= tag;
        vld_q[idx] <= {{(SUBS-1){1'b0}}, 1'b1} << sub;
      end else begin
        vld_q[idx][sub] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd) data_q[slot] <= upd_data;
  end
endmodule

module subblk_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_write,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic wr_q, seen_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      seen_rd <= 1'b0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      wr_q    <= cpu_req_write;
      seen_rd <= 1'b0;
    end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
      seen_rd <= 1'b1;
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid && cpu_req_ready);
  a_r8_no_ready_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
  a_r2_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_hit |-> !seen_rd);
  a_r6_store_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && wr_q |-> mem_req_write);
endmodule

bind subblk_cache subblk_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_write(cpu_req_write), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr)
);

// File: tb/subblk_cache_tb_top.sv
module subblk_cache_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [11:0] cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, cpu_rsp_hit;
  logic [31:0] cpu_rsp_rdata;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [11:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata = '0;

  int n_chk = 0, n_bad = 0;

  logic [4:0]  mt  [8];
  logic [3:0]  mv  [8];
  logic [31:0] md  [32];
  logic [31:0] mem [1024];

  always #5 clk = ~clk;

  subblk_cache dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                        output bit got_hit, output logic [31:0] got_data);
    int idx = int'(a[6:4]);
    int sub = int'(a[3:2]);
    logic [4:0] tg = a[11:7];
    bit eh = mv[idx][sub] && (mt[idx] == tg);
    logic [31:0] ed = eh ? md[idx*4+sub] : mem[a[11:2]];
    int nrd = 0, nwr = 0;
    bit sent = 0, rspd = 0, done = 0;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R8 ready idle", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R8 rsp pulse", 32'(cpu_rsp_valid), 0);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int c = 0; c < 100 && !done; c++) begin
      if (cpu_rsp_valid) begin
        done = 1;
      end else begin
        chk(cpu_req_ready == 1'b0, "R8 busy", 32'(cpu_req_ready), 0);
        mem_rsp_valid = 1'b0;
        if (sent && !wr && !rspd && ($urandom % 2 == 0)) begin
          mem_rsp_valid = 1'b1; mem_rsp_rdata = mem[a[11:2]]; rspd = 1;
        end
        mem_req_ready = 1'b0;
        if (mem_req_valid && !sent) begin
          chk(mem_req_addr == {a[11:2], 2'b00}, "R3 addr", 32'(mem_req_addr), 32'({a[11:2], 2'b00}));
          chk(mem_req_write == wr, "R6 write flag", 32'(mem_req_write), 32'(wr));
          if (wr) chk(mem_req_wdata == wd, "R7 wdata", mem_req_wdata, wd);
          mem_req_ready = 1'($urandom % 2);
          if (mem_req_ready) begin
            sent = 1;
            if (mem_req_write) nwr++; else nrd++;
          end
        end
        @(negedge clk);
      end
    end
    mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
    chk(done, "R8 response timeout", 32'(done), 1);
    got_hit = cpu_rsp_hit; got_data = cpu_rsp_rdata;
    chk(cpu_rsp_hit == eh, "R2 hit flag", 32'(cpu_rsp_hit), 32'(eh));
    if (!wr) chk(cpu_rsp_rdata == ed, "R3 load data", cpu_rsp_rdata, ed);
    chk(nrd == ((wr || eh) ? 0 : 1), "R3/R6 read count", 32'(nrd), 32'((wr || eh) ? 0 : 1));
    chk(nwr == (wr ? 1 : 0), "R7 write count", 32'(nwr), 32'(wr));
    if (wr || !eh) begin
      if (mt[idx] != tg) begin mt[idx] = tg; mv[idx] = '0; end
      mv[idx][sub] = 1'b1;
      md[idx*4+sub] = wr ? wd : mem[a[11:2]];
    end
    if (wr) mem[a[11:2]] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0100_0193) ^ 32'hA5A5_0000;
    for (int i = 0; i < 8; i++) begin mt[i] = '0; mv[i] = '0; end
    for (int i = 0; i < 32; i++) md[i] = '0;
    repeat (3) @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R1 rsp", 32'(cpu_rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem req", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    access(0, 12'h0A0, 0, h, d); chk(h == 0, "R1 first load misses", 32'(h), 0);
    access(0, 12'h0A0, 0, h, d); chk(h == 1, "R2 repeat load hits", 32'(h), 1);
    access(0, 12'h0A3, 0, h, d); chk(h == 1, "R9 byte bits ignored", 32'(h), 1);
    access(0, 12'h0A4, 0, h, d); chk(h == 0, "R4 partial miss", 32'(h), 0);
    access(0, 12'h0A0, 0, h, d); chk(h == 1, "R4 sibling kept", 32'(h), 1);
    access(0, 12'h120, 0, h, d); chk(h == 0, "R5 tag conflict", 32'(h), 0);
    access(0, 12'h0A4, 0, h, d); chk(h == 0, "R5 sibling invalidated", 32'(h), 0);
    access(1, 12'h1A8, 32'hDEAD_BEEF, h, d); chk(h == 0, "R6 store miss", 32'(h), 0);
    access(0, 12'h1A8, 0, h, d); chk(h == 1 && d == 32'hDEAD_BEEF, "R6 stored word hits", d, 32'hDEAD_BEEF);
    access(0, 12'h1A0, 0, h, d); chk(h == 0, "R6 no line fill", 32'(h), 0);
    access(1, 12'h1A8, 32'h1234_5678, h, d); chk(h == 1, "R7 store hit", 32'(h), 1);
    access(0, 12'h1A9, 0, h, d); chk(d == 32'h1234_5678, "R7 store hit updates", d, 32'h1234_5678);
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      a = {2'b00, 3'($urandom % 4), 3'($urandom % 2), 2'($urandom), 2'($urandom)};
      access(1'($urandom % 3 == 0), a, $urandom, h, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule